// File: doc/BRIEF.md
# Address Tenure Master with Bus Busy Tracking

This block drives the address phase of a split-transaction processor bus for a single bus master. The core holds a request (address plus a 5-bit transfer type) until the block accepts it. The block accepts only when the arbiter grants the bus, the shared busy line is clear, and its own view of bus ownership is clear. It then drives a one-cycle transfer-start strobe, keeps address-busy asserted until the address acknowledge arrives, and hands the bus back with a one-cycle busy-negation phase before all drivers go to high impedance.

Each driven bus signal has its own output-enable, so a pad ring can build the shared tri-state lines. The block also listens to the shared bus. A transfer-start from another master sets a local busy flag and produces a one-cycle snoop-valid pulse that carries the captured address and type. An address acknowledge clears the flag. A parameter mask marks which transfer-type codes are address-only, and those codes raise no implied data-bus request.

Top module: `addr_tenure_master`

## Requirements
- R1: A request is accepted (`req_ready` = 1, combinational) only in a cycle where the block is idle, `req_valid` = 1, `grant_in` = 1, `busy_in` = 0 and the tracked busy flag is clear.
- R2: In the cycle after acceptance, `start_out` = 1, `busy_out` = 1, `start_oe` = `busy_oe` = `attr_oe` = 1, and `addr_out`/`ttype_out` equal the accepted request.
- R3: `start_out` is high for exactly one cycle. In the remaining cycles of the tenure it is driven low with `start_oe` = 1.
- R4: `busy_out` stays 1 until `ack_in` is sampled high during the tenure. In the next cycle `busy_out` = 0 with `busy_oe` = 1, and `start_oe` = `attr_oe` = 0. One cycle later `busy_oe` = 0.
- R5: `data_req` is high together with `start_out` exactly when bit `ttype` of `ADDR_ONLY_MASK` is 0. A mask bit i set to 1 marks code i as address-only. The default mask is 32'h0000_0C1F (codes 0–4, 10 and 11).
- R6: While `busy_in` = 1, no request is accepted and no transfer-start is driven.
- R7: The tracked busy flag is set by a sampled `start_in` and cleared by a sampled `ack_in`. When both arrive in the same cycle, it is set. While the flag is set, no request is accepted.
- R8: One cycle after `start_in` is sampled, `snoop_valid` = 1 for one cycle, with `snoop_addr`/`snoop_ttype` equal to the `bus_addr_in`/`bus_ttype_in` sampled with it.
- R9: Synchronous active-high `rst` returns the block to idle with every output-enable low, every strobe low, and the tracked busy flag clear.
- R10: No request is accepted while an own tenure or its release cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core has a pending request |
| req_addr | input | AW | Request address |
| req_ttype | input | 5 | Request transfer type |
| req_ready | output | 1 | Request accepted this cycle |
| grant_in | input | 1 | Address-bus grant from arbiter |
| busy_in | input | 1 | Shared address-busy line as seen on the bus |
| ack_in | input | 1 | Address acknowledge from the bus |
| start_in | input | 1 | Transfer-start from another master |
| bus_addr_in | input | AW | Address observed on the bus |
| bus_ttype_in | input | 5 | Transfer type observed on the bus |
| start_out | output | 1 | Own transfer-start strobe |
| start_oe | output | 1 | Drive enable for transfer-start |
| busy_out | output | 1 | Own address-busy value |
| busy_oe | output | 1 | Drive enable for address-busy |
| addr_out | output | AW | Driven address |
| ttype_out | output | 5 | Driven transfer type |
| attr_oe | output | 1 | Drive enable for address and type |
| data_req | output | 1 | Implied data-bus request |
| snoop_valid | output | 1 | Snoop strobe for another master's start |
| snoop_addr | output | AW | Captured snoop address |
| snoop_ttype | output | 5 | Captured snoop transfer type |

## Verification
The bench builds the block with an 8-bit address and the default address-only mask. This small width lets it sweep all 32 transfer-type codes against acknowledge delays of zero, one and two cycles, so every mask bit and every release alignment is exercised. The same configuration keeps the blocking cases short to run: busy line high, grant absent, tracked flag set, simultaneous start and acknowledge, and reset in the middle of a tenure.

// File: rtl/atm_pkg.sv
package atm_pkg;

    localparam int TT_W     = 5;
    localparam int TT_CODES = 1 << TT_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TENURE  = 2'd1,
        ST_RELEASE = 2'd2
    } tenure_state_e;

    typedef struct packed {
        logic start;
        logic busy;
        logic attr;
    } drive_en_t;

    function automatic logic is_addr_only(input logic [TT_CODES-1:0] mask,
                                          input logic [TT_W-1:0]     tt);
        return mask[tt];
    endfunction

endpackage

// File: rtl/atm_busy_tracker.sv
module atm_busy_tracker (
    input  logic clk,
    input  logic rst,
    input  logic start_in,
    input  logic ack_in,
    output logic busy_q
);
    // Start has priority: an acknowledge in the same cycle closes the earlier tenure.
    always_ff @(posedge clk) begin
        if (rst)           busy_q <= 1'b0;
        else if (start_in) busy_q <= 1'b1;
        else if (ack_in)   busy_q <= 1'b0;
    end
endmodule

// File: rtl/atm_snoop_capture.sv
module atm_snoop_capture
    import atm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_in,
    input  logic [AW-1:0]   addr_in,
    input  logic [TT_W-1:0] ttype_in,
    output logic            snoop_valid,
    output logic [AW-1:0]   snoop_addr,
    output logic [TT_W-1:0] snoop_ttype
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snoop_valid <= 1'b0;
            snoop_addr  <= '0;
            snoop_ttype <= '0;
        end else begin
            snoop_valid <= start_in;
            if (start_in) begin
                snoop_addr  <= addr_in;
                snoop_ttype <= ttype_in;
            end
        end
    end
endmodule

// File: rtl/atm_tenure_fsm.sv
module atm_tenure_fsm
    import atm_pkg::*;
#(
    parameter int                  AW             = 32,
    parameter logic [TT_CODES-1:0] ADDR_ONLY_MASK = 32'h0000_0C1F
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic [TT_W-1:0] req_ttype,
    input  logic            grant_in,
    input  logic            busy_in,
    input  logic            trk_busy,
    input  logic            ack_in,
    output logic            req_ready,
    output logic            start_out,
    output logic            busy_out,
    output logic            data_req,
    output logic [AW-1:0]   addr_out,
    output logic [TT_W-1:0] ttype_out,
    output drive_en_t       oe
);
    tenure_state_e   state_q;
    logic            first_q;
    logic            dreq_q;
    logic [AW-1:0]   addr_q;
    logic [TT_W-1:0] tt_q;

    assign req_ready = (state_q == ST_IDLE) && req_valid && grant_in
                       && !busy_in && !trk_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
            dreq_q  <= 1'b0;
            addr_q  <= '0;
            tt_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_ready) begin
                        state_q <= ST_TENURE;
                        first_q <= 1'b1;
                        dreq_q  <= !is_addr_only(ADDR_ONLY_MASK, req_ttype);
                        addr_q  <= req_addr;
                        tt_q    <= req_ttype;
                    end
                end
                ST_TENURE: begin
                    first_q <= 1'b0;
                    dreq_q  <= 1'b0;
                    if (ack_in) state_q <= ST_RELEASE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        oe.start  = (state_q == ST_TENURE);
        oe.attr   = (state_q == ST_TENURE);
        oe.busy   = (state_q == ST_TENURE) || (state_q == ST_RELEASE);
        start_out = first_q;
        data_req  = dreq_q;
        busy_out  = (state_q == ST_TENURE);
        addr_out  = oe.attr ? addr_q : '0;
        ttype_out = oe.attr ? tt_q   : '0;
    end
endmodule

// File: rtl/addr_tenure_master.sv
module addr_tenure_master
    import atm_pkg::*;
#(
    parameter int                  AW             = 32,
    parameter logic [TT_CODES-1:0] ADDR_ONLY_MASK = 32'h0000_0C1F
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic [TT_W-1:0] req_ttype,
    output logic            req_ready,
    input  logic            grant_in,
    input  logic            busy_in,
    input  logic            ack_in,
    input  logic            start_in,
    input  logic [AW-1:0]   bus_addr_in,
    input  logic [TT_W-1:0] bus_ttype_in,
    output logic            start_out,
    output logic            start_oe,
    output logic            busy_out,
    output logic            busy_oe,
    output logic [AW-1:0]   addr_out,
    output logic [TT_W-1:0] ttype_out,
    output logic            attr_oe,
    output logic            data_req,
    output logic            snoop_valid,
    output logic [AW-1:0]   snoop_addr,
    output logic [TT_W-1:0] snoop_ttype
);
    logic      trk_busy;
    drive_en_t oe;

    atm_busy_tracker u_tracker (
        .clk      (clk),
        .rst      (rst),
        .start_in (start_in),
        .ack_in   (ack_in),
        .busy_q   (trk_busy)
    );

    atm_snoop_capture #(.AW(AW)) u_snoop (
        .clk         (clk),
        .rst         (rst),
        .start_in    (start_in),
        .addr_in     (bus_addr_in),
        .ttype_in    (bus_ttype_in),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .snoop_ttype (snoop_ttype)
    );

    atm_tenure_fsm #(.AW(AW), .ADDR_ONLY_MASK(ADDR_ONLY_MASK)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ttype (req_ttype),
        .grant_in  (grant_in),
        .busy_in   (busy_in),
        .trk_busy  (trk_busy),
        .ack_in    (ack_in),
        .req_ready (req_ready),
        .start_out (start_out),
        .busy_out  (busy_out),
        .data_req  (data_req),
        .addr_out  (addr_out),
        .ttype_out (ttype_out),
        .oe        (oe)
    );

    assign start_oe = oe.start;
    assign busy_oe  = oe.busy;
    assign attr_oe  = oe.attr;
endmodule

// File: rtl/atm_checker.sv
module atm_checker (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic busy_in,
    input logic ack_in,
    input logic start_in,
    input logic start_out,
    input logic start_oe,
    input logic busy_out,
    input logic busy_oe,
    input logic attr_oe,
    input logic data_req,
    input logic snoop_valid
);
    AST_ACCEPT_TO_START: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> start_out); // R2
    AST_START_DRIVES_ALL: assert property (@(posedge clk) disable iff (rst)
        start_out |-> (busy_out && busy_oe && start_oe && attr_oe)); // R2
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start_out |=> !start_out); // R3
    AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (busy_out && ack_in) |=> (!busy_out && busy_oe && !start_oe && !attr_oe)); // R4
    AST_BUSY_OE_DROP: assert property (@(posedge clk) disable iff (rst)
        (busy_oe && !busy_out) |=> !busy_oe); // R4
    AST_DATA_REQ_WITH_START: assert property (@(posedge clk) disable iff (rst)
        data_req |-> start_out); // R5
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_in |-> !req_ready); // R6
    AST_TRACK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        start_in |=> !req_ready); // R7
    AST_SNOOP_PULSE: assert property (@(posedge clk) disable iff (rst)
        start_in |=> snoop_valid); // R8
    AST_NO_ACCEPT_IN_TENURE: assert property (@(posedge clk) disable iff (rst)
        busy_oe |-> !req_ready); // R10
endmodule

bind addr_tenure_master atm_checker u_atm_checker (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .busy_in     (busy_in),
    .ack_in      (ack_in),
    .start_in    (start_in),
    .start_out   (start_out),
    .start_oe    (start_oe),
    .busy_out    (busy_out),
    .busy_oe     (busy_oe),
    .attr_oe     (attr_oe),
    .data_req    (data_req),
    .snoop_valid (snoop_valid)
);

// File: tb/addr_tenure_master_bench.sv
module addr_tenure_master_bench;
    localparam int          AW   = 8;
    localparam logic [31:0] MASK = 32'h0000_0C1F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [4:0]    req_ttype = '0;
    logic          req_ready;
    logic          grant_in = 1'b0;
    logic          busy_in = 1'b0;
    logic          ack_in = 1'b0;
    logic          start_in = 1'b0;
    logic [AW-1:0] bus_addr_in = '0;
    logic [4:0]    bus_ttype_in = '0;
    logic          start_out, start_oe, busy_out, busy_oe, attr_oe, data_req, snoop_valid;
    logic [AW-1:0] addr_out, snoop_addr;
    logic [4:0]    ttype_out, snoop_ttype;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    addr_tenure_master #(.AW(AW), .ADDR_ONLY_MASK(MASK)) u_addr_tenure_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ttype(req_ttype), .req_ready(req_ready), .grant_in(grant_in),
        .busy_in(busy_in), .ack_in(ack_in), .start_in(start_in),
        .bus_addr_in(bus_addr_in), .bus_ttype_in(bus_ttype_in),
        .start_out(start_out), .start_oe(start_oe), .busy_out(busy_out),
        .busy_oe(busy_oe), .addr_out(addr_out), .ttype_out(ttype_out),
        .attr_oe(attr_oe), .data_req(data_req), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .snoop_ttype(snoop_ttype)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #5;
    endtask

    task automatic run_tenure(input logic [AW-1:0] a, input logic [4:0] tt, input int d);
        req_valid = 1'b1; req_addr = a; req_ttype = tt; grant_in = 1'b1;
        #1 chk("R1 accept when clear", req_ready, 1);
        tick;
        req_valid = 1'b0; grant_in = 1'b0;
        chk("R2 start", start_out, 1);
        chk("R2 busy", busy_out, 1);
        chk("R2 enables", {start_oe, busy_oe, attr_oe}, 3'b111);
        chk("R2 addr", addr_out, a);
        chk("R2 ttype", ttype_out, tt);
        chk("R5 data request", data_req, MASK[tt] ? 0 : 1);
        req_valid = 1'b1; grant_in = 1'b1;
        #1 chk("R10 no accept in tenure", req_ready, 0);
        req_valid = 1'b0; grant_in = 1'b0;
        for (int i = 0; i < d; i++) begin
            tick;
            chk("R3 start low", start_out, 0);
            chk("R3 start driven", start_oe, 1);
            chk("R4 busy held", busy_out, 1);
            chk("R5 no late data request", data_req, 0);
        end
        ack_in = 1'b1;
        tick;
        ack_in = 1'b0;
        chk("R4 busy negated", busy_out, 0);
        chk("R4 busy still driven", busy_oe, 1);
        chk("R4 start and attr released", {start_oe, attr_oe, start_out}, 3'b000);
        req_valid = 1'b1; grant_in = 1'b1;
        #1 chk("R10 no accept in release", req_ready, 0);
        req_valid = 1'b0; grant_in = 1'b0;
        tick;
        chk("R4 busy released", busy_oe, 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick; tick;
        chk("R9 reset enables", {start_oe, busy_oe, attr_oe}, 3'b000);
        chk("R9 reset strobes", {start_out, busy_out, data_req, snoop_valid}, 4'b0000);
        rst = 1'b0;
        tick;

        for (int tt = 0; tt < 32; tt++)
            for (int d = 0; d < 3; d++)
                run_tenure(AW'(tt * 7 + d), 5'(tt), d);

        // R1: grant absent
        req_valid = 1'b1; grant_in = 1'b0;
        #1 chk("R1 no grant", req_ready, 0);
        tick;
        chk("R1 no start without grant", start_out, 0);

        // R6: external busy
        grant_in = 1'b1; busy_in = 1'b1;
        #1 chk("R6 busy blocks accept", req_ready, 0);
        tick; tick;
        chk("R6 no start while busy", {start_out, busy_oe}, 2'b00);
        busy_in = 1'b0;
        #1 chk("R6 accept after busy clears", req_ready, 1);
        req_valid = 1'b0; grant_in = 1'b0;
        tick;

        // R7/R8: another master's tenure
        start_in = 1'b1; bus_addr_in = 8'hA5; bus_ttype_in = 5'h12;
        tick;
        start_in = 1'b0;
        chk("R8 snoop valid", snoop_valid, 1);
        chk("R8 snoop addr", snoop_addr, 8'hA5);
        chk("R8 snoop ttype", snoop_ttype, 5'h12);
        req_valid = 1'b1; grant_in = 1'b1;
        #1 chk("R7 tracked busy blocks", req_ready, 0);
        tick;
        chk("R8 snoop single cycle", snoop_valid, 0);
        chk("R7 no start while tracked", start_out, 0);
        req_valid = 1'b0;
        ack_in = 1'b1;
        tick;
        ack_in = 1'b0;
        req_valid = 1'b1;
        #1 chk("R7 ack clears tracked busy", req_ready, 1);
        req_valid = 1'b0;

        // R7: start and ack together -> set
        start_in = 1'b1; ack_in = 1'b1; bus_addr_in = 8'h3C;
        tick;
        start_in = 1'b0; ack_in = 1'b0;
        req_valid = 1'b1;
        #1 chk("R7 start wins over ack", req_ready, 0);
        req_valid = 1'b0;

        // R9: reset clears tracker
        rst = 1'b1;
        tick;
        rst = 1'b0;
        req_valid = 1'b1;
        #1 chk("R9 reset clears tracked busy", req_ready, 1);
        tick;
        req_valid = 1'b0; grant_in = 1'b0;
        chk("R2 start after reset", start_out, 1);
        rst = 1'b1;
        tick;
        rst = 1'b0;
        chk("R9 mid-tenure reset enables", {start_oe, busy_oe, attr_oe}, 3'b000);
        chk("R9 mid-tenure reset strobes", {start_out, busy_out}, 2'b00);
        tick;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule